// File: doc/BRIEF.md
# Write-back MSI snoop coherence controller

This block keeps one processor's direct-mapped, write-back cache coherent with its peers on a shared, atomic snooping bus. Each cache line holds one data word and is in one of three states: Invalid, Shared (a clean copy that can only be read) or Exclusive (the only copy, writable, and dirty relative to memory). The processor side holds a request until the block reports completion. Hits finish locally. Misses become bus transactions, and each one waits for its grant.

The snoop side watches the misses that other caches place on the bus. When this cache owns a dirty copy of the requested line, it drives the line's word as intervention data and raises an abort so that memory does not answer. It then demotes or drops its copy. A snoop and a processor access can arrive in the same cycle. In that case the snoop is applied first, and the processor access is decided against the line state the snoop leaves behind.

Top module: `msi_snoop_ctl`

## Requirements
- R1: After reset every line is Invalid, `bus_req` is low and `bus_cmd` reads 00. Whenever `bus_req` is low, `bus_cmd` is 00.
- R2: A processor read that finds the line Invalid, or valid with another tag, and clean, requests the bus with command 01 (read miss) and the request's address. In the grant cycle it completes with `bus_rdata` on `cpu_rdata`, and the line becomes Shared.
- R3: A processor write that finds the line Invalid, Shared, or clean with another tag, requests the bus with command 10 (write miss). In the grant cycle it completes, and the line becomes Exclusive holding `cpu_wdata`.
- R4: A read to a valid line with a matching tag, or a write to an Exclusive line with a matching tag, completes in the cycle of the request without raising `bus_req`. A read returns the stored word.
- R5: A miss to a line held Exclusive under another tag first places a write-back (command 11) carrying the old line's address and word. Only after that grant does it place the read or write miss for the new address.
- R6: A snooped read miss (01) that hits a line held Exclusive raises `snp_abort` in the snoop cycle with the line's word on `snp_data`, and leaves the line Shared.
- R7: A snooped write miss (10) that hits a line held Exclusive raises `snp_abort` with the word on `snp_data`, and leaves the line Invalid.
- R8: A snooped write miss that hits a line held Shared leaves the line Invalid without raising `snp_abort`.
- R9: A snooped read miss to a Shared line, a snoop with a non-matching tag, and a snooped write-back (11) raise no abort and leave the line's state and word unchanged.
- R10: A bus miss never completes before its grant. While `bus_req` is high and `bus_gnt` is low, `cpu_done` stays low.
- R11: When a snoop hit and a processor access to the same line share a cycle, the snoop's state change is applied first, and the processor access is decided against the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address (tag above the index bits) |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | Request completes in this cycle |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_done` on a read |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 00 idle, 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Block address of the transaction |
| bus_wdata | output | DATA_W | Word carried by a write-back |
| bus_gnt | input | 1 | Grant; the transaction happens in this cycle |
| bus_rdata | input | DATA_W | Fill word for a read miss, sampled with the grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_abort | output | 1 | Dirty owner supplies the block; memory must not answer |
| snp_data | output | DATA_W | Intervention word, valid with `snp_abort` |

## Verification
Completion and snoop responses are combinational. A hit raises `cpu_done` in the cycle the request appears, a miss raises it in the grant cycle, and `snp_abort` with `snp_data` answers in the cycle of the snoop. A state change becomes visible from the next cycle, so the bench probes state with a later access and counts the bus commands that access produces. Inputs are driven on the falling edge and outputs are sampled 1 ns later, before the next rising edge. Miss latency is checked as an exact cycle count against the grant delay the bench chooses, which also covers the two bus turns of a victim write-back.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_IDLE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_t;

  // state a line takes after a snoop that hits it
  function automatic line_st_t snoop_next(input line_st_t st, input bus_cmd_t cmd);
    line_st_t n;
    n = st;
    if (cmd == BC_WRMISS) n = LS_I;
    else if (cmd == BC_RDMISS && st == LS_E) n = LS_S;
    return n;
  endfunction

  function automatic logic is_dirty(input line_st_t st);
    return st == LS_E;
  endfunction

  function automatic logic is_miss_cmd(input bus_cmd_t cmd);
    return cmd == BC_RDMISS || cmd == BC_WRMISS;
  endfunction

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  output line_st_t          ra_st,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output line_st_t          rb_st,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [DATA_W-1:0] rb_data,
  input  logic              cw_en,
  input  logic [IDX_W-1:0]  cw_idx,
  input  line_st_t          cw_st,
  input  logic [TAG_W-1:0]  cw_tag,
  input  logic [DATA_W-1:0] cw_data,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  line_st_t          sw_st
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_all  [LINES];
  logic [TAG_W-1:0]  tag_all [LINES];
  logic [DATA_W-1:0] dat_all [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_t          st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;
    // processor update wins; on a shared index it was decided from the post-snoop state
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= LS_I;
        tag_q <= '0;
        dat_q <= '0;
      end else if (cw_en && cw_idx == IDX_W'(g)) begin
        st_q  <= cw_st;
        tag_q <= cw_tag;
        dat_q <= cw_data;
      end else if (sw_en && sw_idx == IDX_W'(g)) begin
        st_q  <= sw_st;
      end
    end
    assign st_all[g]  = st_q;
    assign tag_all[g] = tag_q;
    assign dat_all[g] = dat_q;
  end

  assign ra_st   = st_all[ra_idx];
  assign ra_tag  = tag_all[ra_idx];
  assign ra_data = dat_all[ra_idx];
  assign rb_st   = st_all[rb_idx];
  assign rb_tag  = tag_all[rb_idx];
  assign rb_data = dat_all[rb_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  bus_cmd_t          cmd,
  input  logic [TAG_W-1:0]  stag,
  input  line_st_t          st,
  input  logic [TAG_W-1:0]  ltag,
  input  logic [DATA_W-1:0] ldata,
  output logic              hit,
  output line_st_t          nst,
  output logic              abort,
  output logic [DATA_W-1:0] sdata
);
  always_comb begin
    hit   = snp_valid && st != LS_I && ltag == stag && is_miss_cmd(cmd);
    nst   = hit ? snoop_next(st, cmd) : st;
    abort = hit && is_dirty(st);
    sdata = abort ? ldata : '0;
  end

  // R9
  wb_snoop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && cmd == BC_WBACK) |-> !abort);

  // R6
  abort_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (snp_valid && ltag == stag && nst != LS_E));

endmodule

// File: rtl/msi_cpu_unit.sv
module msi_cpu_unit
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    we,
  input  logic [TAG_W-1:0]        tag,
  input  logic [IDX_W-1:0]        idx,
  input  logic [DATA_W-1:0]       wdata,
  input  line_st_t                eff_st,
  input  logic [TAG_W-1:0]        line_tag,
  input  logic [DATA_W-1:0]       line_data,
  input  logic                    gnt,
  input  logic [DATA_W-1:0]       bus_rdata,
  output logic                    done,
  output logic [DATA_W-1:0]       rdata,
  output logic                    breq,
  output bus_cmd_t                bcmd,
  output logic [TAG_W+IDX_W-1:0]  baddr,
  output logic [DATA_W-1:0]       bwdata,
  output logic                    lw_en,
  output line_st_t                lw_st,
  output logic [DATA_W-1:0]       lw_data
);
  logic tag_eq, rd_hit, wr_hit, need_wb, miss;

  always_comb begin
    tag_eq  = line_tag == tag;
    rd_hit  = req && !we && eff_st != LS_I && tag_eq;
    wr_hit  = req && we && eff_st == LS_E && tag_eq;
    need_wb = req && !rd_hit && !wr_hit && is_dirty(eff_st) && !tag_eq;
    miss    = req && !rd_hit && !wr_hit && !need_wb;

    breq   = need_wb || miss;
    bcmd   = need_wb ? BC_WBACK : (miss ? (we ? BC_WRMISS : BC_RDMISS) : BC_IDLE);
    baddr  = need_wb ? {line_tag, idx} : {tag, idx};
    bwdata = need_wb ? line_data : '0;

    done  = rd_hit || wr_hit || (miss && gnt);
    rdata = rd_hit ? line_data : ((miss && gnt && !we) ? bus_rdata : '0);

    lw_en   = wr_hit || (breq && gnt);
    lw_st   = need_wb ? LS_I : (we ? LS_E : LS_S);
    lw_data = need_wb ? line_data : (we ? wdata : bus_rdata);
  end

  // R10
  miss_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (breq && !gnt) |-> !done);

  // R4
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit || wr_hit) |-> !breq);

  // R1
  idle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !breq |-> bcmd == BC_IDLE);

  // R5
  wb_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (breq && gnt && bcmd == BC_WBACK) |=> !(breq && bcmd == BC_WBACK));

endmodule

// File: rtl/msi_snoop_ctl.sv
module msi_snoop_ctl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_abort,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag;
  line_st_t          a_st, b_st, eff_st, snp_nst, lw_st;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data, lw_data;
  logic              snp_hit, lw_en;
  bus_cmd_t          bcmd;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(cpu_idx), .ra_st(a_st), .ra_tag(a_tag), .ra_data(a_data),
    .rb_idx(snp_idx), .rb_st(b_st), .rb_tag(b_tag), .rb_data(b_data),
    .cw_en(lw_en), .cw_idx(cpu_idx), .cw_st(lw_st), .cw_tag(cpu_tag), .cw_data(lw_data),
    .sw_en(snp_hit), .sw_idx(snp_idx), .sw_st(snp_nst)
  );

  msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .cmd(bus_cmd_t'(snp_cmd)), .stag(snp_tag),
    .st(b_st), .ltag(b_tag), .ldata(b_data),
    .hit(snp_hit), .nst(snp_nst), .abort(snp_abort), .sdata(snp_data)
  );

  // the snoop is applied first: the processor sees the state it leaves
  assign eff_st = (snp_hit && snp_idx == cpu_idx) ? snp_nst : a_st;

  msi_cpu_unit #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_cpu (
    .clk(clk), .rst_n(rst_n),
    .req(cpu_req), .we(cpu_we), .tag(cpu_tag), .idx(cpu_idx), .wdata(cpu_wdata),
    .eff_st(eff_st), .line_tag(a_tag), .line_data(a_data),
    .gnt(bus_gnt), .bus_rdata(bus_rdata),
    .done(cpu_done), .rdata(cpu_rdata),
    .breq(bus_req), .bcmd(bcmd), .baddr(bus_addr), .bwdata(bus_wdata),
    .lw_en(lw_en), .lw_st(lw_st), .lw_data(lw_data)
  );

  assign bus_cmd = bcmd;

  // R11
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_abort && cpu_req && cpu_we && snp_addr == cpu_addr) |-> !cpu_done);

endmodule

// File: tb/msi_snoop_ctl_bench.sv
module msi_snoop_ctl_bench;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_gnt = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'd0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_abort;
  logic [DW-1:0] snp_data;

  always #10 clk = ~clk;

  msi_snoop_ctl u_msi_snoop_ctl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_abort(snp_abort), .snp_data(snp_data)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [DW-1:0] mem [256];
  logic [1:0]    lg_cmd  [8];
  logic [AW-1:0] lg_addr [8];
  logic [DW-1:0] lg_data [8];
  int lg_n;
  int op_cycles;
  logic [DW-1:0] op_rd;

  localparam logic [AW-1:0] LA = 8'h10;  // index 0
  localparam logic [AW-1:0] LB = 8'h14;  // index 0, other tag
  localparam logic [AW-1:0] LC = 8'h21;  // index 1

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one processor access served by a bus responder granting after dly waiting cycles
  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d, input int dly);
    int waitc = 0;
    bit fin = 1'b0;
    lg_n = 0;
    op_cycles = 0;
    op_rd = '0;
    @(negedge clk);
    snp_valid = 1'b0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    while (!fin && op_cycles < 40) begin
      #1;
      op_cycles++;
      if (cpu_done) begin
        op_rd = cpu_rdata; fin = 1'b1;
      end else if (bus_req) begin
        if (waitc >= dly) begin
          bus_gnt = 1'b1;
          bus_rdata = mem[bus_addr];
          #1;
          if (lg_n < 8) begin
            lg_cmd[lg_n] = bus_cmd; lg_addr[lg_n] = bus_addr; lg_data[lg_n] = bus_wdata;
            lg_n++;
          end
          if (bus_cmd == 2'b11) mem[bus_addr] = bus_wdata;
          if (cpu_done) begin op_rd = cpu_rdata; fin = 1'b1; end
          waitc = 0;
        end else begin
          waitc++;
        end
      end
      @(negedge clk);
      bus_gnt = 1'b0;
      bus_rdata = '0;
    end
    cpu_req = 1'b0;
  endtask

  // a single-cycle snoop; memory takes the intervention word as the write-back
  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, output logic ab, output logic [DW-1:0] sd);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    #1;
    ab = snp_abort; sd = snp_data;
    if (snp_abort) mem[a] = snp_data;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R1 bus_req after reset", {31'd0, bus_req}, 32'd0);
    chk("R1 bus_cmd after reset", {30'd0, bus_cmd}, 32'd0);
    chk("R1 abort after reset", {31'd0, snp_abort}, 32'd0);
    cpu_op(1'b0, LA, '0, 2);
    chk("R1 read after reset misses", lg_n, 1);
    chk("R2 read miss command 01", {30'd0, lg_cmd[0]}, 32'd1);
    chk("R2 read miss address", {24'd0, lg_addr[0]}, {24'd0, LA});
    chk("R2 fill word returned", op_rd, mem[LA]);
    chk("R10 miss waits for grant", op_cycles, 3);
  endtask

  task automatic t_shared_hits;
    logic ab; logic [DW-1:0] sd;
    cpu_op(1'b0, LA, '0, 3);
    chk("R4 read hit in Shared no bus", lg_n, 0);
    chk("R4 read hit word", op_rd, mem[LA]);
    chk("R4 read hit same cycle", op_cycles, 1);
    snoop(2'b01, LA, ab, sd);
    chk("R9 snoop read on Shared no abort", {31'd0, ab}, 32'd0);
    cpu_op(1'b0, LA, '0, 0);
    chk("R9 Shared kept after snoop read", lg_n, 0);
  endtask

  task automatic t_write_upgrade;
    cpu_op(1'b1, LA, 32'h1111_0000, 1);
    chk("R3 write on Shared issues one command", lg_n, 1);
    chk("R3 write miss command 10", {30'd0, lg_cmd[0]}, 32'd2);
    chk("R10 write miss waits for grant", op_cycles, 2);
    cpu_op(1'b0, LA, '0, 0);
    chk("R3 line Exclusive holds written word", op_rd, 32'h1111_0000);
    cpu_op(1'b1, LA, 32'h2222_0000, 0);
    chk("R4 write hit in Exclusive no bus", lg_n, 0);
    cpu_op(1'b0, LA, '0, 0);
    chk("R4 write hit stored", op_rd, 32'h2222_0000);
  endtask

  task automatic t_snoop_dirty;
    logic ab; logic [DW-1:0] sd;
    snoop(2'b01, LA, ab, sd);
    chk("R6 snoop read on Exclusive aborts", {31'd0, ab}, 32'd1);
    chk("R6 intervention word", sd, 32'h2222_0000);
    cpu_op(1'b0, LA, '0, 0);
    chk("R6 line readable after demotion", lg_n, 0);
    cpu_op(1'b1, LA, 32'h3333_0000, 0);
    chk("R6 line Shared so write misses", lg_n, 1);
    snoop(2'b10, LA, ab, sd);
    chk("R7 snoop write on Exclusive aborts", {31'd0, ab}, 32'd1);
    chk("R7 intervention word", sd, 32'h3333_0000);
    cpu_op(1'b0, LA, '0, 0);
    chk("R7 line Invalid so read misses", lg_n, 1);
    chk("R7 refill sees supplied word", op_rd, 32'h3333_0000);
    snoop(2'b10, LA, ab, sd);
    chk("R8 snoop write on Shared no abort", {31'd0, ab}, 32'd0);
    cpu_op(1'b0, LA, '0, 0);
    chk("R8 line Invalid so read misses", lg_n, 1);
  endtask

  task automatic t_victim;
    logic ab; logic [DW-1:0] sd;
    cpu_op(1'b1, LA, 32'h4444_0000, 0);
    cpu_op(1'b0, LB, '0, 1);
    chk("R5 two bus turns", lg_n, 2);
    chk("R5 first is write-back 11", {30'd0, lg_cmd[0]}, 32'd3);
    chk("R5 write-back victim address", {24'd0, lg_addr[0]}, {24'd0, LA});
    chk("R5 write-back victim word", lg_data[0], 32'h4444_0000);
    chk("R5 then read miss 01", {30'd0, lg_cmd[1]}, 32'd1);
    chk("R5 read miss new address", {24'd0, lg_addr[1]}, {24'd0, LB});
    chk("R5 new word returned", op_rd, mem[LB]);
    chk("R10 each turn waits for grant", op_cycles, 4);
    snoop(2'b01, LA, ab, sd);
    chk("R5 victim no longer owned", {31'd0, ab}, 32'd0);
  endtask

  task automatic t_other_snoops;
    logic ab; logic [DW-1:0] sd;
    cpu_op(1'b1, LB, 32'h5555_0000, 0);
    chk("R3 write on Shared other line", lg_n, 1);
    snoop(2'b10, LA, ab, sd);
    chk("R9 tag mismatch no abort", {31'd0, ab}, 32'd0);
    cpu_op(1'b0, LB, '0, 0);
    chk("R9 tag mismatch state kept", lg_n, 0);
    chk("R9 tag mismatch word kept", op_rd, 32'h5555_0000);
    snoop(2'b11, LB, ab, sd);
    chk("R9 snooped write-back no abort", {31'd0, ab}, 32'd0);
    cpu_op(1'b1, LB, 32'h5556_0000, 0);
    chk("R9 still Exclusive after write-back snoop", lg_n, 0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'b01; snp_addr = LB;
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = LB; cpu_wdata = 32'h6666_0000;
    #1;
    chk("R11 snoop served abort", {31'd0, snp_abort}, 32'd1);
    chk("R11 snoop served word", snp_data, 32'h5556_0000);
    chk("R11 write not a hit", {31'd0, cpu_done}, 32'd0);
    chk("R11 write sees Shared, write miss", {30'd0, bus_cmd}, 32'd2);
    mem[LB] = snp_data;
    cpu_op(1'b1, LB, 32'h6666_0000, 0);
    chk("R11 write completes through bus", lg_n, 1);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'b01; snp_addr = LB;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = LB;
    #1;
    chk("R11 read hit alongside snoop", {31'd0, cpu_done}, 32'd1);
    chk("R11 read word", cpu_rdata, 32'h6666_0000);
    chk("R11 read needs no bus", {31'd0, bus_req}, 32'd0);
    chk("R6 abort with word", snp_data, 32'h6666_0000);
    @(negedge clk);
    snp_valid = 1'b0; cpu_req = 1'b0;
  endtask

  task automatic t_cold_write;
    cpu_op(1'b1, LC, 32'h7777_0000, 2);
    chk("R3 write on Invalid command 10", {30'd0, lg_cmd[0]}, 32'd2);
    chk("R3 write on Invalid one turn", lg_n, 1);
    cpu_op(1'b0, LC, '0, 0);
    chk("R4 read hit Exclusive", op_rd, 32'h7777_0000);
    chk("R4 read hit no bus", lg_n, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 | i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shared_hits();
    t_write_upgrade();
    t_snoop_dirty();
    t_victim();
    t_other_snoops();
    t_same_cycle();
    t_cold_write();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule